// File: doc/BRIEF.md
# I2C SCL Phase Strobe Prescaler

This block turns a fast system clock into the timing marks that an I2C master's bit engine needs to build SCL. Each SCL period is cut into five equal phases. A one-cycle strobe marks the entry into each phase, and a phase index tells the engine which phase is current. The engine uses these marks to place SCL edges, SDA changes and the sampling point.

The length of each phase is set by a divider word: a phase lasts `div + 1` system cycles. After the fifth phase, the block adds a fixed idle stretch of `OVERHEAD` cycles (eight by default) before phase 0 starts again. One SCL period therefore lasts `5 * (div + 1) + 8` cycles. For a 133 MHz system clock, software picks the divider as `(ceil(f_clk / f_scl) - 8) / 5 - 1`, which gives about 100 kHz with div = 263 and about 400 kHz with div = 64.

The divider word is captured only at the start of a period, so a phase is never cut short. Clearing the enable or raising the soft reset stops the generator at once and returns it to phase 0.

Top module: `scl_prescaler`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block leaves that edge with `phase_strobe` all zero and `phase_idx` equal to 0.
- R2: At the first clock edge where `enable` is high and `soft_rst` is low after a stopped state, the block starts. In the cycle that follows that edge, `phase_strobe` equals 1 (bit 0 set) and `phase_idx` is 0.
- R3: Bit k of `phase_strobe` marks entry into phase k. At most one bit is set at a time. A set bit lasts one cycle. While bit k is set, `phase_idx` equals k.
- R4: Phases run in the order 0, 1, 2, 3, 4 and then wrap to 0. Within a period, the strobe of phase k+1 comes exactly `div + 1` cycles after the strobe of phase k.
- R5: The strobe of phase 0 comes `div + 1 + OVERHEAD` cycles (div + 9 by default) after the strobe of phase 4. A full period is therefore `5 * (div + 1) + OVERHEAD` cycles.
- R6: Between strobes, `phase_idx` holds its value, including through the idle stretch, where it stays 4.
- R7: `div_value` is sampled only at the edge that starts phase 0. A change made during a period leaves the remaining phases and the idle stretch of that period unchanged, and it applies from the next period on.
- R8: A clock edge that sees `enable` low leaves the block with no strobe and `phase_idx` 0. It stays that way until a restart as in R2.
- R9: `soft_rst` high stops the block as in R8 even when `enable` is high. Releasing it restarts the block as in R2.
- R10: A divider of 0 gives one-cycle phases. The largest divider the width allows gives `2^DIV_W`-cycle phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Run request; low stops the generator |
| soft_rst | input | 1 | Soft reset; high stops the generator and has priority over enable |
| div_value | input | DIV_W | Phase length minus one, in system cycles |
| phase_strobe | output | NUM_PHASES | One-cycle, one-hot phase entry marks |
| phase_idx | output | $clog2(NUM_PHASES) | Index of the current phase |

## Verification
The bench builds the block with a 6-bit divider, five phases and an eight-cycle idle stretch. With this width, the largest divider (63) gives a 328-cycle period, so the top of the range and the zero divider can both be measured over whole periods in a short run. It also lets random dividers cover the whole legal range. Strobe spacing is measured edge to edge. This covers the phase-4-to-phase-0 interval, divider changes made in the middle of a period, and stops and restarts through both enable and soft reset, at arbitrary points in a phase.

// File: rtl/scl_pre_pkg.sv
// Shared types for the SCL phase strobe prescaler.
// Assumes: nothing beyond the standard language.
package scl_pre_pkg;

    // Sequencer state: stopped, inside a phase, or in the idle stretch.
    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_PHASE = 2'd1,
        SEQ_GAP   = 2'd2
    } seq_state_e;

    // Events the sequencer raises in the current cycle.
    typedef struct packed {
        logic start;    // phase 0 begins at the next edge
        logic advance;  // next phase (1..N-1) begins at the next edge
    } seq_evt_t;

endpackage

// File: rtl/scl_pre_count.sv
// Up counter with synchronous clear and a compare against a limit.
// Used both for the phase length and for the idle stretch.
// Assumes: the caller clears the counter when it reaches its limit.
module scl_pre_count #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         run,
    input  logic [W-1:0] limit,
    output logic         at_limit
);

    logic [W-1:0] cnt_q;

    // Count while running; clear has priority.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Terminal count flag.
    always_comb begin
        at_limit = (cnt_q == limit);
    end

endmodule

// File: rtl/scl_pre_shadow.sv
// Shadow copy of the divider word, loaded only at a period start.
// Assumes: load is a one-cycle pulse from the sequencer.
module scl_pre_shadow #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q
);

    // Capture the divider at the period boundary only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= d_in;
        end
    end

endmodule

// File: rtl/scl_pre_seq.sv
// Phase sequencer: walks phases 0..NUM_PHASES-1, then the idle stretch,
// then wraps. Raises start/advance events for the strobe register.
// Assumes: ph_done and gap_done are the terminal flags of the counters.
module scl_pre_seq
    import scl_pre_pkg::*;
#(
    parameter int NUM_PHASES = 5,
    parameter bit HAS_GAP    = 1'b1,
    localparam int IDX_W     = (NUM_PHASES > 1) ? $clog2(NUM_PHASES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic             ph_done,
    input  logic             gap_done,
    output seq_state_e       state,
    output logic [IDX_W-1:0] phase,
    output seq_evt_t         evt
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_PHASES - 1);

    logic last_phase_end;

    // Decode the end of the final phase and the events.
    always_comb begin
        last_phase_end = (state == SEQ_PHASE) && ph_done && (phase == LAST);
        evt.start   = go && ((state == SEQ_IDLE) ||
                             ((state == SEQ_GAP) && gap_done) ||
                             (last_phase_end && !HAS_GAP));
        evt.advance = go && (state == SEQ_PHASE) && ph_done && (phase != LAST);
    end

    // State and phase index update.
    always_ff @(posedge clk) begin
        if (!rst_n || !go) begin
            state <= SEQ_IDLE;
            phase <= '0;
        end else if (evt.start) begin
            state <= SEQ_PHASE;
            phase <= '0;
        end else if (evt.advance) begin
            phase <= phase + 1'b1;
        end else if (last_phase_end) begin
            state <= SEQ_GAP;
        end
    end

endmodule

// File: rtl/scl_prescaler.sv
// SCL phase strobe prescaler top.
// Splits each SCL period into NUM_PHASES phases of (div+1) cycles each,
// followed by OVERHEAD idle cycles, and emits a one-cycle one-hot strobe
// on entry to each phase together with the current phase index.
// Assumes: synchronous active-low reset; div_value static or changed freely
// (it is sampled only at period starts).
module scl_prescaler
    import scl_pre_pkg::*;
#(
    parameter int DIV_W      = 16,
    parameter int NUM_PHASES = 5,
    parameter int OVERHEAD   = 8,
    localparam int IDX_W     = (NUM_PHASES > 1) ? $clog2(NUM_PHASES) : 1,
    localparam bit HAS_GAP   = (OVERHEAD > 0),
    localparam int GAP_W     = (OVERHEAD > 1) ? $clog2(OVERHEAD) : 1,
    localparam int GAP_LIM   = HAS_GAP ? OVERHEAD - 1 : 0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  enable,
    input  logic                  soft_rst,
    input  logic [DIV_W-1:0]      div_value,
    output logic [NUM_PHASES-1:0] phase_strobe,
    output logic [IDX_W-1:0]      phase_idx
);

    logic             go;
    logic [DIV_W-1:0] div_sh;
    logic             ph_done;
    logic             gap_done;
    logic             ph_clear;
    logic             gap_clear;
    seq_state_e       state;
    logic [IDX_W-1:0] phase;
    seq_evt_t         evt;
    logic [NUM_PHASES-1:0] strobe_q;

    // Run qualifier: soft reset overrides enable.
    always_comb begin
        go        = enable && !soft_rst;
        ph_clear  = !go || (state != SEQ_PHASE) || ph_done;
        gap_clear = !go || (state != SEQ_GAP) || gap_done;
    end

    scl_pre_shadow #(.W(DIV_W)) u_shadow (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (evt.start),
        .d_in  (div_value),
        .q     (div_sh)
    );

    scl_pre_count #(.W(DIV_W)) u_phase_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (ph_clear),
        .run      (1'b1),
        .limit    (div_sh),
        .at_limit (ph_done)
    );

    scl_pre_count #(.W(GAP_W)) u_gap_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (gap_clear),
        .run      (1'b1),
        .limit    (GAP_W'(GAP_LIM)),
        .at_limit (gap_done)
    );

    scl_pre_seq #(
        .NUM_PHASES (NUM_PHASES),
        .HAS_GAP    (HAS_GAP)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (go),
        .ph_done  (ph_done),
        .gap_done (gap_done),
        .state    (state),
        .phase    (phase),
        .evt      (evt)
    );

    // One strobe flop per phase, set for the first cycle of that phase.
    for (genvar k = 0; k < NUM_PHASES; k++) begin : g_strobe
        if (k == 0) begin : g_first
            // Phase 0 entry comes from a period start.
            always_ff @(posedge clk) begin
                if (!rst_n) strobe_q[k] <= 1'b0;
                else        strobe_q[k] <= evt.start;
            end
        end else begin : g_rest
            // Phase k entry comes from advancing out of phase k-1.
            always_ff @(posedge clk) begin
                if (!rst_n) strobe_q[k] <= 1'b0;
                else        strobe_q[k] <= evt.advance &&
                                           (phase == IDX_W'(k - 1));
            end
        end
    end

    // Drive outputs.
    always_comb begin
        phase_strobe = strobe_q;
        phase_idx    = phase;
    end

endmodule

// File: rtl/scl_prescaler_chk.sv
// Port-level assertions for scl_prescaler, attached with bind.
// Assumes: synchronous active-low reset on rst_n.
module scl_prescaler_chk #(
    parameter int NUM_PHASES = 5,
    parameter int IDX_W      = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  enable,
    input logic                  soft_rst,
    input logic [NUM_PHASES-1:0] phase_strobe,
    input logic [IDX_W-1:0]      phase_idx
);

    logic go_c;
    always_comb go_c = enable && !soft_rst;

    AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(phase_strobe)); // R3
    AST_STROBE_MATCHES_IDX: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_strobe != '0) |-> phase_strobe[phase_idx]); // R3
    AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_strobe != '0) |=> (phase_strobe != $past(phase_strobe))); // R3
    AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(phase_idx) < NUM_PHASES)); // R4
    AST_IDX_STEPS_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase_strobe != '0) && (phase_idx != '0)) |->
            (phase_idx == $past(phase_idx) + 1'b1)); // R4
    AST_IDX_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (go_c && $past(go_c) && (phase_strobe == '0)) |-> $stable(phase_idx)); // R6
    AST_STOP_ON_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> ((phase_strobe == '0) && (phase_idx == '0))); // R8
    AST_STOP_ON_SOFT_RST: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> ((phase_strobe == '0) && (phase_idx == '0))); // R9

endmodule

bind scl_prescaler scl_prescaler_chk #(
    .NUM_PHASES (NUM_PHASES),
    .IDX_W      (IDX_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (enable),
    .soft_rst     (soft_rst),
    .phase_strobe (phase_strobe),
    .phase_idx    (phase_idx)
);

// File: tb/scl_prescaler_test.sv
module scl_prescaler_test;

    localparam int DW  = 6;
    localparam int NP  = 5;
    localparam int OVH = 8;
    localparam int IW  = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b0;
    logic          soft_rst = 1'b0;
    logic [DW-1:0] div_value = '0;
    logic [NP-1:0] phase_strobe;
    logic [IW-1:0] phase_idx;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    scl_prescaler #(.DIV_W(DW), .NUM_PHASES(NP), .OVERHEAD(OVH)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .soft_rst     (soft_rst),
        .div_value    (div_value),
        .phase_strobe (phase_strobe),
        .phase_idx    (phase_idx)
    );

    // Spacing between the strobe of phase prev and the next one.
    function automatic int exp_gap(int prev, int d);
        return d + 1 + ((prev == NP - 1) ? OVH : 0);
    endfunction

    function automatic int next_idx(int prev);
        return (prev + 1) % NP;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // Wait for the next strobe and check its distance, index and encoding.
    task automatic next_strobe(int gap, int idx, string req, int held);
        int n = 0;
        int hold_err = 0;
        do begin
            tick();
            n++;
            if (phase_strobe == '0 && int'(phase_idx) != held) hold_err++;
        end while (phase_strobe == '0 && n < 2000);
        check(n == gap, req, n, gap);
        check(int'(phase_idx) == idx, "R4 order", int'(phase_idx), idx);
        check(phase_strobe == NP'(1 << idx), "R3 onehot",
              int'(phase_strobe), 1 << idx);
        check(hold_err == 0, "R6 idx hold", hold_err, 0);
    endtask

    // Start from stopped with divider d and measure nstr strobes.
    task automatic run_from_stop(int d, int nstr, string req);
        int prev = 0;
        div_value = DW'(d);
        enable = 1'b1;
        soft_rst = 1'b0;
        tick();
        check(phase_strobe == NP'(1) && phase_idx == '0, "R2 start",
              int'(phase_strobe), 1);
        for (int i = 0; i < nstr; i++) begin
            next_strobe(exp_gap(prev, d), next_idx(prev),
                        (prev == NP - 1) ? "R5 overhead" : req, prev);
            prev = next_idx(prev);
        end
    endtask

    task automatic stop_and_check(string req);
        int bad = 0;
        tick();
        check(phase_strobe == '0 && phase_idx == '0, req,
              int'(phase_idx), 0);
        for (int i = 0; i < 12; i++) begin
            tick();
            if (phase_strobe != '0 || phase_idx != '0) bad++;
        end
        check(bad == 0, req, bad, 0);
    endtask

    initial begin : watchdog
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000 && !done) begin
                failures++;
                checks++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin : stim
        int d;
        int bad;
        int wait_n;
        void'($urandom(32'd7321));
        // R1: reset state, even with enable high
        enable = 1'b1;
        div_value = 6'd3;
        repeat (3) tick();
        check(phase_strobe == '0 && phase_idx == '0, "R1 reset",
              int'(phase_strobe), 0);
        enable = 1'b0;
        tick();
        rst_n = 1'b1;
        tick();
        check(phase_strobe == '0 && phase_idx == '0, "R1 after reset idle",
              int'(phase_idx), 0);

        // R4/R5 nominal spacing, two periods, divider 3
        run_from_stop(3, 2 * NP, "R4 spacing");
        enable = 1'b0;
        stop_and_check("R8 disable");

        // R10 divider 0 and maximum
        run_from_stop(0, 2 * NP, "R10 div zero");
        enable = 1'b0;
        stop_and_check("R8 disable");
        run_from_stop((1 << DW) - 1, NP + 1, "R10 div max");
        enable = 1'b0;
        stop_and_check("R8 disable");

        // R7 divider change mid-period
        run_from_stop(2, 2, "R4 spacing");
        div_value = 6'd9;
        next_strobe(3, 3, "R7 old div kept", 2);
        next_strobe(3, 4, "R7 old div kept", 3);
        next_strobe(3 + OVH, 0, "R7 old div in overhead", 4);
        next_strobe(10, 1, "R7 new div applied", 0);
        next_strobe(10, 2, "R7 new div applied", 1);

        // R9 soft reset has priority over enable
        soft_rst = 1'b1;
        stop_and_check("R9 soft reset");
        soft_rst = 1'b0;
        tick();
        check(phase_strobe == NP'(1) && phase_idx == '0, "R9 restart",
              int'(phase_strobe), 1);
        next_strobe(10, 1, "R9 restart spacing", 0);

        // R8 stop during the overhead stretch
        next_strobe(10, 2, "R4 spacing", 1);
        next_strobe(10, 3, "R4 spacing", 2);
        next_strobe(10, 4, "R4 spacing", 3);
        repeat (13) tick();
        check(phase_idx == 3'd4 && phase_strobe == '0, "R6 idx in overhead",
              int'(phase_idx), 4);
        enable = 1'b0;
        stop_and_check("R8 stop in overhead");

        // Random dividers and random stop points
        for (int it = 0; it < 20; it++) begin
            d = int'($urandom_range(0, (1 << DW) - 1));
            run_from_stop(d, int'($urandom_range(1, 12)), "R4 random");
            wait_n = int'($urandom_range(0, d + 3));
            repeat (wait_n) tick();
            if ($urandom_range(0, 1) == 0) enable = 1'b0;
            else soft_rst = 1'b1;
            stop_and_check((soft_rst) ? "R9 random stop" : "R8 random stop");
            soft_rst = 1'b0;
            enable = 1'b0;
        end

        // R8: disabled with a nonzero divider stays quiet
        bad = 0;
        div_value = 6'd1;
        for (int i = 0; i < 40; i++) begin
            tick();
            if (phase_strobe != '0) bad++;
        end
        check(bad == 0, "R8 stays idle", bad, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule